// File: doc/BRIEF.md
# Multi-format stereo serial audio transmitter

This block turns parallel stereo samples into a serial audio stream. The bit clock, the left/right clock and the optional word clock come from outside. The block oversamples them on a faster system clock and acts only on the bit clock edges it is told to drive on. Each word is 24 bits and goes out MSB first. A receiver that wants fewer bits captures the leading ones and ignores the rest. A 2-bit format input places the word inside each half frame. The format can start the word at the left/right transition, one bit period after it, 16 bit periods after it, or at the rising edge of the word clock.

Software or an upstream engine hands over a left/right sample pair through a ready/valid handshake into a single holding register. The pair is moved into the transmit path at the start of every left half frame. If no new pair is waiting at that point, the previous pair is sent again and an underrun flag is raised. A mute request zeroes every word that begins while it is asserted. A word that is already on the line is finished unchanged.

Top module: `stereo_serial_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sdata_out` is 0, `s_ready` is 1 and `underrun_flag` is 0.
- R2: With `fmt_sel`=0, the MSB is driven at the drive edge where the half frame begins. The remaining 23 bits follow MSB first, one per drive edge. After that the line is 0 until the next word starts.
- R3: With `fmt_sel`=1, each word starts one bit period later than with `fmt_sel`=0. The line is 0 on the first drive edge of the half frame.
- R4: With `fmt_sel`=2, each word starts 16 bit periods after the half-frame boundary.
- R5: With `fmt_sel`=3, a half frame begins at the drive edge where `wck_in` is first seen high, and the word starts on that same edge. `lrck_in` level is not used to find the boundary. `lrck_in` low at that edge marks a left word and high marks a right word.
- R6: With `drive_fall`=0, `sdata_out` changes only after rising edges of `bclk_in`. With `drive_fall`=1, it changes only after falling edges.
- R7: A half-frame boundary that arrives before all 24 bits are out ends the current word at once. The line then reads 0 until the next word starts.
- R8: `s_ready` is 1 only while the holding register is empty. It drops in the cycle after a handshake. The held pair is taken over at the next left half-frame start.
- R9: If the holding register is empty at a left half-frame start, the previous pair is sent again and `underrun_flag` goes to 1. The flag clears at the next left start that finds data.
- R10: While `mute_req` is high, every word that starts is sent as all zeros. A word already in progress when `mute_req` rises is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | Left/right clock, low selects left |
| wck_in | input | 1 | Word clock used in format 3 |
| fmt_sel | input | 2 | 0 left-aligned, 1 left-aligned plus one bit, 2 offset by 16 bits, 3 word-clock aligned |
| drive_fall | input | 1 | 1 drives data on falling bit clock edges, 0 on rising edges |
| mute_req | input | 1 | Zero the words that start while high |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| sdata_out | output | 1 | Serial data line |
| underrun_flag | output | 1 | Last left start found no new pair |

## Verification
The bench runs all four formats under both drive edges, with random and extreme samples such as a lone MSB, a lone LSB, all ones and alternating bits. It targets the points where an off-by-one start offset, a wrong drive edge or a missing abort would slip the stream by a bit, or leave a stale tail of the old word on the line after an early boundary. Each of these shows up as shifted or extra ones on `sdata_out`. Half frames of 20 and 32 periods cut words short under left-aligned and 16-bit-offset formats. A skipped push must repeat the old pair and raise the flag, not send zeros. Muting halfway through a word must leave that word intact and blank only the words that follow.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT     = 2'd0,
    FMT_LEFT_DLY = 2'd1,
    FMT_OFFSET   = 2'd2,
    FMT_WCLK     = 2'd3
  } fmt_e;
endpackage

// File: rtl/sstx_edge_sense.sv
// Registers the external clocks into the system domain and flags the
// selected bit clock edge.
module sstx_edge_sense (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic lrck_in,
  input  logic wck_in,
  input  logic drive_fall,
  output logic drv_edge,
  output logic lr_s,
  output logic wck_s
);
  logic bclk_q, bclk_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      lr_s    <= 1'b0;
      wck_s   <= 1'b0;
    end else begin
      bclk_q  <= bclk_in;
      bclk_qq <= bclk_q;
      lr_s    <= lrck_in;
      wck_s   <= wck_in;
    end
  end

  assign drv_edge = drive_fall ? (bclk_qq & ~bclk_q) : (bclk_q & ~bclk_qq);
endmodule

// File: rtl/sstx_frame_timer.sv
// Finds half-frame boundaries, counts drive edges since the boundary and
// says when the word of the selected format starts.
module sstx_frame_timer
  import sstx_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int OFFSET = 16
) (
  input  logic clk,
  input  logic rst,
  input  fmt_e fmt,
  input  logic drv_edge,
  input  logic lr_s,
  input  logic wck_s,
  output logic boundary,
  output logic chan_now,
  output logic left_start,
  output logic word_start
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             lr_prev, wck_prev, chan_q;
  logic [CNT_W-1:0] bitpos, idx_now, start_idx;

  always_comb begin
    unique case (fmt)
      FMT_LEFT_DLY: start_idx = CNT_W'(1);
      FMT_OFFSET:   start_idx = CNT_W'(OFFSET);
      default:      start_idx = '0;
    endcase
  end

  assign boundary   = drv_edge & ((fmt == FMT_WCLK) ? (wck_s & ~wck_prev)
                                                    : (lr_s ^ lr_prev));
  assign idx_now    = boundary ? '0 : bitpos;
  assign chan_now   = boundary ? lr_s : chan_q;
  assign left_start = boundary & ~lr_s;
  assign word_start = drv_edge & (idx_now == start_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev  <= 1'b0;
      wck_prev <= 1'b0;
      chan_q   <= 1'b0;
      bitpos   <= CNT_MAX;
    end else if (drv_edge) begin
      lr_prev  <= lr_s;
      wck_prev <= wck_s;
      chan_q   <= chan_now;
      bitpos   <= (idx_now == CNT_MAX) ? CNT_MAX : idx_now + 1'b1;
    end
  end
endmodule

// File: rtl/sstx_sample_hold.sv
// One-entry holding register behind a ready/valid handshake. The pair in
// use is refreshed at each left half-frame start.
module sstx_sample_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  input  logic              left_start,
  output logic [WORD_W-1:0] eff_l,
  output logic [WORD_W-1:0] eff_r,
  output logic              underrun_flag
);
  logic              full;
  logic [WORD_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic              take;

  assign s_ready = ~full;
  assign take    = s_valid & ~full;
  // bypass so a word starting on the left-start edge sees the new pair
  assign eff_l   = (left_start & full) ? hold_l : cur_l;
  assign eff_r   = (left_start & full) ? hold_r : cur_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      full          <= 1'b0;
      hold_l        <= '0;
      hold_r        <= '0;
      cur_l         <= '0;
      cur_r         <= '0;
      underrun_flag <= 1'b0;
    end else begin
      if (left_start) begin
        if (full) begin
          cur_l         <= hold_l;
          cur_r         <= hold_r;
          full          <= 1'b0;
          underrun_flag <= 1'b0;
        end else begin
          underrun_flag <= 1'b1;
        end
      end
      if (take) begin
        hold_l <= s_left;
        hold_r <= s_right;
        full   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sstx_shifter.sv
// Loads a word at its start edge and shifts it out MSB first.
module sstx_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_edge,
  input  logic              boundary,
  input  logic              word_start,
  input  logic              chan_now,
  input  logic              mute_req,
  input  logic [WORD_W-1:0] eff_l,
  input  logic [WORD_W-1:0] eff_r,
  output logic              sdata_out
);
  localparam int RW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh, word;
  logic [RW-1:0]     remain;

  assign word = mute_req ? '0 : (chan_now ? eff_r : eff_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      remain    <= '0;
      sdata_out <= 1'b0;
    end else if (word_start) begin
      sdata_out <= word[WORD_W-1];
      sh        <= word << 1;
      remain    <= RW'(WORD_W - 1);
    end else if (drv_edge) begin
      if (boundary) begin
        sdata_out <= 1'b0;
        remain    <= '0;
      end else if (remain != '0) begin
        sdata_out <= sh[WORD_W-1];
        sh        <= sh << 1;
        remain    <= remain - 1'b1;
      end else begin
        sdata_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sstx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int OFFSET = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              lrck_in,
  input  logic              wck_in,
  input  logic [1:0]        fmt_sel,
  input  logic              drive_fall,
  input  logic              mute_req,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  output logic              sdata_out,
  output logic              underrun_flag
);
  localparam int CNT_W = $clog2(OFFSET + WORD_W) + 1;

  fmt_e              fmt;
  logic              drv_edge, lr_s, wck_s;
  logic              boundary, chan_now, left_start, word_start, word_load;
  logic [WORD_W-1:0] eff_l, eff_r;

  assign fmt       = fmt_e'(fmt_sel);
  assign word_load = word_start;

  sstx_edge_sense u_edge (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .lrck_in(lrck_in),
    .wck_in(wck_in), .drive_fall(drive_fall),
    .drv_edge(drv_edge), .lr_s(lr_s), .wck_s(wck_s)
  );

  sstx_frame_timer #(.CNT_W(CNT_W), .OFFSET(OFFSET)) u_timer (
    .clk(clk), .rst(rst), .fmt(fmt), .drv_edge(drv_edge), .lr_s(lr_s),
    .wck_s(wck_s), .boundary(boundary), .chan_now(chan_now),
    .left_start(left_start), .word_start(word_start)
  );

  sstx_sample_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .left_start(left_start),
    .eff_l(eff_l), .eff_r(eff_r), .underrun_flag(underrun_flag)
  );

  sstx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .drv_edge(drv_edge), .boundary(boundary),
    .word_start(word_start), .chan_now(chan_now), .mute_req(mute_req),
    .eff_l(eff_l), .eff_r(eff_r), .sdata_out(sdata_out)
  );
endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic mute_req,
  input logic sdata_out,
  input logic underrun_flag,
  input logic drv_edge,
  input logic boundary,
  input logic word_load,
  input logic left_start
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sdata_out && s_ready && !underrun_flag));

  // R6
  drive_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_out) |-> $past(drv_edge));

  // R7
  abort_low_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && !word_load) |=> !sdata_out);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R9
  underrun_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(underrun_flag) |-> $past(left_start));

  // R10
  mute_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (word_load && mute_req) |=> !sdata_out);
endmodule

bind stereo_serial_tx stereo_serial_tx_chk u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .mute_req(mute_req), .sdata_out(sdata_out), .underrun_flag(underrun_flag),
  .drv_edge(drv_edge), .boundary(boundary), .word_load(word_load),
  .left_start(left_start)
);

// File: tb/stereo_serial_tx_test.sv
module stereo_serial_tx_test;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_in = 1'b0, lrck_in = 1'b0, wck_in = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        drive_fall = 1'b0, mute_req = 1'b0, s_valid = 1'b0;
  logic [23:0] s_left = '0, s_right = '0;
  logic        s_ready, sdata_out, underrun_flag;

  int tests = 0, fails = 0;
  logic [23:0] ml, mr, pl, pr, wexp;
  logic        pend, exp_und;
  logic [23:0] corner [0:3];

  always #2.5 clk = ~clk;

  stereo_serial_tx uut (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .lrck_in(lrck_in),
    .wck_in(wck_in), .fmt_sel(fmt_sel), .drive_fall(drive_fall),
    .mute_req(mute_req), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .sdata_out(sdata_out),
    .underrun_flag(underrun_flag)
  );

  function automatic int start_off(input logic [1:0] f, input int wpos);
    case (f)
      2'd1: return 1;
      2'd2: return 16;
      2'd3: return wpos;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_bit(input int k, input logic [23:0] w);
    if (k >= 0 && k < 24) return w[23-k];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'd1: return "R3 delayed-left";
      2'd2: return "R4 offset-16";
      2'd3: return "R5 word-clock";
      default: return "R2 left-aligned";
    endcase
  endfunction

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    chk("R8 ready before push", {23'd0, s_ready}, 24'd1);
    s_valid = 1'b1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R8 ready after push", {23'd0, s_ready}, 24'd0);
    pl = l; pr = r; pend = 1'b1;
  endtask

  // one half frame; data_push: offer a new pair after edge 1; mute_at: edge to raise mute
  task automatic half_frame(input logic lr, input int nbits, input int wpos,
                            input logic data_push, input int mute_at);
    int off = start_off(fmt_sel, wpos);
    int ls  = (fmt_sel == 2'd3) ? wpos : 0;
    for (int j = 0; j < nbits; j++) begin
      logic smp;
      if (j == mute_at) begin @(negedge clk); mute_req = 1'b1; end
      if (data_push && j == 2) push($urandom & 24'hFFFFFF, $urandom & 24'hFFFFFF);
      if (!lr && j == ls) begin
        if (pend) begin ml = pl; mr = pr; pend = 1'b0; exp_und = 1'b0; end
        else exp_und = 1'b1;
      end
      if (j - off == 0) wexp = mute_req ? 24'd0 : (lr ? mr : ml);
      @(negedge clk);
      bclk_in = ~drive_fall;
      lrck_in = lr;
      wck_in  = (fmt_sel == 2'd3) && (j == wpos);
      repeat (HALF - 1) @(negedge clk);
      smp = sdata_out;
      if (j - off >= 0) chk((nbits < off + 24) ? "R7 truncated word" : req_of(fmt_sel),
                            {23'd0, smp}, {23'd0, exp_bit(j - off, wexp)});
      else chk(drive_fall ? "R6 falling-edge idle" : "R6 rising-edge idle",
               {23'd0, smp}, 24'd0);
      @(negedge clk);
      bclk_in = drive_fall;
      repeat (HALF - 1) @(negedge clk);
    end
    if (!lr) chk("R9 underrun flag", {23'd0, underrun_flag}, {23'd0, exp_und});
  endtask

  task automatic restart(input logic [1:0] f, input logic fall);
    @(negedge clk);
    rst = 1'b1; fmt_sel = f; drive_fall = fall; bclk_in = fall;
    lrck_in = 1'b0; wck_in = 1'b0; mute_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ml = '0; mr = '0; pend = 1'b0; exp_und = 1'b0; wexp = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    corner[0] = 24'h800000; corner[1] = 24'h000001;
    corner[2] = 24'hFFFFFF; corner[3] = 24'hA5A5A5;
    restart(2'd0, 1'b0);
    @(negedge clk);
    // R1 reset state
    chk("R1 sdata after reset", {23'd0, sdata_out}, 24'd0);
    chk("R1 ready after reset", {23'd0, s_ready}, 24'd1);
    chk("R1 underrun after reset", {23'd0, underrun_flag}, 24'd0);

    for (int f = 0; f < 4; f++) begin
      for (int e = 0; e < 2; e++) begin
        int nb = (f == 2) ? 48 : 32;
        restart(f[1:0], e[0]);
        push(corner[f], corner[(f + e + 1) % 4]);
        half_frame(1'b1, nb, 3, 1'b0, -1);
        for (int fr = 0; fr < 2; fr++) begin
          half_frame(1'b0, nb, 3, 1'b0, -1);
          half_frame(1'b1, nb, 3, 1'b1, -1);
        end
        // skipped push: old pair repeats, flag rises, then clears (R9)
        half_frame(1'b0, nb, 3, 1'b0, -1);
        half_frame(1'b1, nb, 3, 1'b0, -1);
        half_frame(1'b0, nb, 3, 1'b0, -1);
        half_frame(1'b1, nb, 3, 1'b1, -1);
        half_frame(1'b0, nb, 3, 1'b0, -1);
      end
    end

    // R7 short half frames cut words
    restart(2'd2, 1'b0);
    push(24'hFFFFFF, 24'hFFFFFF);
    half_frame(1'b1, 32, 0, 1'b0, -1);
    half_frame(1'b0, 32, 0, 1'b0, -1);
    half_frame(1'b1, 32, 0, 1'b0, -1);
    restart(2'd0, 1'b1);
    push(24'hFFFFFF, 24'h7FFFFF);
    half_frame(1'b1, 20, 0, 1'b0, -1);
    half_frame(1'b0, 20, 0, 1'b0, -1);
    half_frame(1'b1, 20, 0, 1'b0, -1);

    // R10 mute raised mid-word: current word intact, following words zero
    restart(2'd0, 1'b0);
    push(24'hFFFFFF, 24'hC3C3C3);
    half_frame(1'b1, 32, 0, 1'b0, -1);
    half_frame(1'b0, 32, 0, 1'b0, 5);
    half_frame(1'b1, 32, 0, 1'b0, -1);
    @(negedge clk); mute_req = 1'b0;
    half_frame(1'b0, 32, 0, 1'b0, -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule